// File: doc/BRIEF.md
# Receive Statistics Counters with Overflow Interrupt

This block keeps two free-running event counters for a network controller's receive path. The first counts frames that were addressed to this node but never stored, either because reception was switched off or because the receive FIFO had no room. The second counts collisions observed on the medium while the node itself was not sending. The address filter and the collision detector sit outside the block and present one-cycle event pulses to it.

Software may read both counts at any moment but cannot load or clear them. The only ways back to zero are the controller's stop command and hardware reset. Counting does not depend on whether the receiver is enabled, so the missed-frame counter can act as a traffic monitor while reception is off. When the missed-frame counter wraps to zero, a sticky overflow flag is raised. A second sticky flag is raised on every single missed frame, for software that expects a per-event indication. Each flag has its own mask. The interrupt output combines the unmasked flags under one global enable. Both flags are cleared by writing ones.

Top module: `rx_stat_counters`

## Requirements
- R1: `miss_cnt_o` increases by one, modulo 2^CNT_W, in the cycle after each cycle with `miss_evt_i` high. It holds its value otherwise. No input exists that enables or disables this counting.
- R2: `coll_cnt_o` increases by one, modulo 2^CNT_W, in the cycle after each cycle with `coll_evt_i` high and `xmit_active_i` low. A collision pulse while `xmit_active_i` is high leaves it unchanged.
- R3: A missed-frame event that takes `miss_cnt_o` from all ones to zero sets `ovf_sts_o` in the same cycle that the count reads zero.
- R4: Every missed-frame event sets `miss_sts_o` in the following cycle.
- R5: A cycle with `stop_i` high makes both counts and both status flags zero in the next cycle. This holds even when events or a wrap occur in that same cycle.
- R6: Status flags are write-one-to-clear. When `sts_wr_i` is high, bit 0 of `sts_wdata_i` clears `miss_sts_o` and bit 1 clears `ovf_sts_o`. A zero bit changes nothing. A set condition in the same cycle takes priority over the clear.
- R7: `irq_o` equals `int_en_i & ((miss_sts_o & ~miss_mask_i) | (ovf_sts_o & ~ovf_mask_i))` at all times, with no register delay from the mask and enable inputs.
- R8: A wrap of the collision counter sets no status flag and does not affect `irq_o`.
- R9: After reset both counts and both status flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stop_i | input | 1 | Stop command; clears counts and flags |
| miss_evt_i | input | 1 | One frame addressed to this node was dropped |
| coll_evt_i | input | 1 | One collision detected on the medium |
| xmit_active_i | input | 1 | Node is transmitting; collisions are not counted |
| sts_wr_i | input | 1 | Write strobe for the status clear |
| sts_wdata_i | input | 2 | Ones clear flags: bit 0 miss, bit 1 overflow |
| miss_mask_i | input | 1 | Masks the per-miss flag from the interrupt |
| ovf_mask_i | input | 1 | Masks the overflow flag from the interrupt |
| int_en_i | input | 1 | Global interrupt enable |
| miss_cnt_o | output | CNT_W | Missed-frame count |
| coll_cnt_o | output | CNT_W | Receive collision count |
| miss_sts_o | output | 1 | Sticky per-miss flag |
| ovf_sts_o | output | 1 | Sticky missed-count overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W set to 4, so both counters wrap every sixteen events. A sweep of several thousand cycles therefore passes through hundreds of wraps on each counter. Along the way it hits the corners where a wrap meets a stop, where a wrap meets a status clear, and where a collision coincides with transmission. The sweep also steps the mask and enable combinations through all eight values. A bench model computes every expected count and flag arithmetically and compares them cycle by cycle.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int STS_MISS_BIT = 0;
    localparam int STS_OVF_BIT  = 1;
    localparam int NUM_STS      = 2;

    typedef logic [NUM_STS-1:0] sts_vec_t;
endpackage

// File: rtl/stat_wrap_counter.sv
module stat_wrap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap_d   = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = wrap_d;

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    // R1 R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R1 R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/stat_sticky_flags.sv
module stat_sticky_flags
    import stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stop_i,
    input  sts_vec_t set_i,
    input  sts_vec_t w1c_i,
    output sts_vec_t flags_o
);
    typedef struct packed {
        sts_vec_t flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_STS; k++) begin
            if (stop_i)        st_d.flags[k] = 1'b0;
            else if (set_i[k]) st_d.flags[k] = 1'b1;
            else if (w1c_i[k]) st_d.flags[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < NUM_STS; g++) begin : g_flag_chk
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!stop_i && set_i[g]) |=> flags_o[g]);

        // R6
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!stop_i && !set_i[g] && w1c_i[g]) |=> !flags_o[g]);

        // R5
        stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stop_i |=> !flags_o[g]);
    end
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
    import stat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_i,
    input  logic             miss_evt_i,
    input  logic             coll_evt_i,
    input  logic             xmit_active_i,
    input  logic             sts_wr_i,
    input  logic [1:0]       sts_wdata_i,
    input  logic             miss_mask_i,
    input  logic             ovf_mask_i,
    input  logic             int_en_i,
    output logic [CNT_W-1:0] miss_cnt_o,
    output logic [CNT_W-1:0] coll_cnt_o,
    output logic             miss_sts_o,
    output logic             ovf_sts_o,
    output logic             irq_o
);
    logic     miss_wrap;
    logic     coll_wrap;
    logic     coll_inc;
    sts_vec_t sts_set;
    sts_vec_t sts_w1c;
    sts_vec_t sts_q;

    assign coll_inc = coll_evt_i & ~xmit_active_i;

    stat_wrap_counter #(.W(CNT_W)) u_miss_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (stop_i),
        .inc_i  (miss_evt_i),
        .cnt_o  (miss_cnt_o),
        .wrap_o (miss_wrap)
    );

    stat_wrap_counter #(.W(CNT_W)) u_coll_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (stop_i),
        .inc_i  (coll_inc),
        .cnt_o  (coll_cnt_o),
        .wrap_o (coll_wrap)
    );

    always_comb begin
        sts_set               = '0;
        sts_set[STS_MISS_BIT] = miss_evt_i;
        sts_set[STS_OVF_BIT]  = miss_wrap;
        sts_w1c               = sts_wr_i ? sts_vec_t'(sts_wdata_i) : '0;
    end

    stat_sticky_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_i  (stop_i),
        .set_i   (sts_set),
        .w1c_i   (sts_w1c),
        .flags_o (sts_q)
    );

    assign miss_sts_o = sts_q[STS_MISS_BIT];
    assign ovf_sts_o  = sts_q[STS_OVF_BIT];
    assign irq_o      = int_en_i & ((miss_sts_o & ~miss_mask_i) |
                                    (ovf_sts_o  & ~ovf_mask_i));

    // R3
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sts_o) |-> (miss_cnt_o == '0));

    // R8
    coll_wrap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_wrap && !miss_wrap && !ovf_sts_o) |=> !ovf_sts_o);

    // R2
    coll_tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && xmit_active_i) |=> $stable(coll_cnt_o));

    // R4
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && miss_evt_i) |=> miss_sts_o);
endmodule

// File: tb/tb_rx_stat_counters.sv
module tb_rx_stat_counters;
    localparam int CNT_W = 4;
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam int NCYC  = 6000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stop_i = 1'b0;
    logic             miss_evt_i = 1'b0;
    logic             coll_evt_i = 1'b0;
    logic             xmit_active_i = 1'b0;
    logic             sts_wr_i = 1'b0;
    logic [1:0]       sts_wdata_i = 2'b00;
    logic             miss_mask_i = 1'b0;
    logic             ovf_mask_i = 1'b0;
    logic             int_en_i = 1'b0;
    logic [CNT_W-1:0] miss_cnt_o;
    logic [CNT_W-1:0] coll_cnt_o;
    logic             miss_sts_o;
    logic             ovf_sts_o;
    logic             irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    int em = 0, ec = 0;
    bit es_miss = 0, es_ovf = 0;

    always #4 clk = ~clk;

    rx_stat_counters #(.CNT_W(CNT_W)) dut (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_irq();
        bit e;
        e = int_en_i & ((es_miss & ~miss_mask_i) | (es_ovf & ~ovf_mask_i));
        check("R7 irq", int'(irq_o), int'(e));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 miss count", int'(miss_cnt_o), 0);
        check("R9 coll count", int'(coll_cnt_o), 0);
        check("R9 miss flag", int'(miss_sts_o), 0);
        check("R9 ovf flag", int'(ovf_sts_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NCYC; i++) begin
            bit  ovf_set, cwrap;
            int  mx;
            mx = i * 37 + (i >> 3);
            stop_i        = (i % 97) == 96 || (i % 211) == 15;
            miss_evt_i    = (mx % 5) < 3;
            coll_evt_i    = (i % 3) != 0;
            xmit_active_i = (i[3] ^ i[6]) == 1'b1;
            sts_wr_i      = (i % 13) == 0 || (i % 29) == 0;
            sts_wdata_i   = 2'(i >> 4);
            miss_mask_i   = i[7];
            ovf_mask_i    = i[8];
            int_en_i      = i[9] | i[2];
            #1;
            check_irq();

            ovf_set = 0;
            cwrap   = 0;
            if (stop_i) begin
                em = 0; ec = 0; es_miss = 0; es_ovf = 0;
            end else begin
                if (miss_evt_i) begin
                    ovf_set = (em == MAXV);
                    em = (em + 1) & MAXV;
                end
                if (coll_evt_i && !xmit_active_i) begin
                    cwrap = (ec == MAXV);
                    ec = (ec + 1) & MAXV;
                end
                if (sts_wr_i && sts_wdata_i[0]) es_miss = 0;
                if (sts_wr_i && sts_wdata_i[1]) es_ovf = 0;
                if (miss_evt_i) es_miss = 1;
                if (ovf_set) es_ovf = 1;
            end

            @(negedge clk);
            if (stop_i) begin
                check("R5 miss count after stop", int'(miss_cnt_o), 0);
                check("R5 coll count after stop", int'(coll_cnt_o), 0);
                check("R5 flags after stop", int'({ovf_sts_o, miss_sts_o}), 0);
            end else begin
                check("R1 miss count", int'(miss_cnt_o), em);
                check(xmit_active_i ? "R2 coll blocked by transmit" : "R2 coll count",
                      int'(coll_cnt_o), ec);
                check(ovf_set ? "R3 overflow on wrap" :
                      (cwrap ? "R8 coll wrap silent" : "R6 ovf flag"),
                      int'(ovf_sts_o), int'(es_ovf));
                check(miss_evt_i ? "R4 miss flag" : "R6 miss flag",
                      int'(miss_sts_o), int'(es_miss));
            end
            check_irq();
        end
        finish_run();
    end
endmodule